// File: doc/BRIEF.md
# Branch Target Buffer with Stored Target Instruction

This block is a small, fully associative branch target cache placed next to instruction fetch. Each valid slot remembers the address of a branch, a 2-bit direction counter, the branch's target address and the instruction word found at that target. Every fetch address is compared against all slots in the same cycle. The block then reports a hit or a miss and gives the address fetch should use next.

On a hit whose counter predicts taken, the stored target instruction is handed to the decoder directly. Fetch can then skip the target and continue at the target plus one instruction, with no instruction-cache access for the target word. A hit that predicts not taken, and any miss, continue sequentially. A not-taken hit keeps its slot.

When a branch resolves, the pipeline presents its address, its real outcome, its real target, the instruction at that target, and what was predicted for it at fetch. The block then trains the counter, corrects a stale target, or installs a new slot in round-robin order. A combinational flag tells the pipeline whether the earlier prediction was wrong.

Top module: `tgt_instr_buffer`

## Requirements
- R1: After reset no slot is valid, so every fetch misses until a slot is installed.
- R2: On a miss, hit, pred_taken and tgt_instr_valid are 0 and next_fetch_addr equals fetch_addr plus INSTR_BYTES (4).
- R3: On a hit whose counter is 2 or 3, pred_taken and tgt_instr_valid are 1, tgt_instr is the stored target instruction and next_fetch_addr is the stored target plus 4. At most one slot matches any address.
- R4: On a hit whose counter is 0 or 1, hit is 1, pred_taken is 0 and next_fetch_addr is fetch_addr plus 4.
- R5: A resolved taken branch that misses installs a slot holding its address, target, target instruction and counter value 2. The slot becomes visible to fetch from the next cycle on.
- R6: A resolved not-taken branch that misses installs nothing.
- R7: A resolved branch that hits moves its slot's counter up by one when taken and down by one when not taken, saturating at 3 and 0.
- R8: A resolved taken branch that hits with a target different from the stored one replaces the stored target and target instruction. A not-taken resolution never changes them.
- R9: Installation uses a round-robin pointer that starts at slot 0 after reset. The ninth installation after reset therefore overwrites the first installed branch.
- R10: mispredict is 1, in the cycle an update is presented, when the resolved direction differs from the predicted one, or when both are taken and the targets differ. Otherwise it is 0.
- R11: While fetch_valid is 0, hit, pred_taken and tgt_instr_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | ADDR_W | Current fetch address |
| hit | output | 1 | A valid slot matches fetch_addr |
| pred_taken | output | 1 | Hit predicted taken |
| tgt_instr_valid | output | 1 | tgt_instr is to be sent to the decoder |
| tgt_instr | output | INSTR_W | Stored instruction at the branch target |
| next_fetch_addr | output | ADDR_W | Address for the next fetch |
| upd_valid | input | 1 | Resolved branch presented |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |
| upd_instr | input | INSTR_W | Instruction at the resolved target |
| upd_pred_taken | input | 1 | Direction that was predicted at fetch |
| upd_pred_target | input | ADDR_W | Target that was predicted at fetch |
| mispredict | output | 1 | Prediction disagreed with resolution |

## Verification
The assertions check several rules on every cycle. No address may match two slots. An idle fetch never hits, and a taken prediction always comes with a hit and a valid target instruction. The allocation pointer steps by exactly one, with wrap-around, on each installation, and valid slots never disappear outside reset. No counter moves by more than one step unless its slot was just reinstalled. The direction part of the mispredict flag is also checked on every cycle. The bench scenarios show the end-to-end effects that depend on what was stored: the exact instruction and next address returned after an install, saturation at both counter ends, target correction, eviction order after eight installs, and target-only mispredicts.

// File: rtl/tib_pkg.sv
package tib_pkg;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_INIT = 2'd2;
  localparam logic [CTR_W-1:0] CTR_MAX  = 2'd3;

  // predicted direction for a counter value
  function automatic logic ctr_says_taken(input logic [CTR_W-1:0] c);
    return c[CTR_W-1];
  endfunction

  // saturating train step
  function automatic logic [CTR_W-1:0] ctr_train(input logic [CTR_W-1:0] c,
                                                 input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 1'b1;
    else       return (c == '0) ? c : c - 1'b1;
  endfunction

  // prediction disagreement between fetch time and resolution
  function automatic logic wrong_guess(input logic act_t, input logic prd_t,
                                       input logic tgt_differs);
    return (act_t != prd_t) || (act_t && prd_t && tgt_differs);
  endfunction
endpackage

// File: rtl/tib_cam.sv
module tib_cam #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ADDR_W-1:0]         key,
  input  logic [ENTRIES*ADDR_W-1:0] tags_flat,
  input  logic [ENTRIES-1:0]        valid,
  output logic [ENTRIES-1:0]        match,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags_flat[i*ADDR_W +: ADDR_W] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/tib_rr_alloc.sv
module tib_rr_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       victim <= '0;
    else if (advance) victim <= (victim == LAST) ? '0 : victim + 1'b1;
  end
endmodule

// File: rtl/tgt_instr_buffer.sv
module tgt_instr_buffer #(
  parameter int ENTRIES     = 8,
  parameter int ADDR_W      = 32,
  parameter int INSTR_W     = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  output logic               hit,
  output logic               pred_taken,
  output logic               tgt_instr_valid,
  output logic [INSTR_W-1:0] tgt_instr,
  output logic [ADDR_W-1:0]  next_fetch_addr,
  input  logic               upd_valid,
  input  logic [ADDR_W-1:0]  upd_addr,
  input  logic               upd_taken,
  input  logic [ADDR_W-1:0]  upd_target,
  input  logic [INSTR_W-1:0] upd_instr,
  input  logic               upd_pred_taken,
  input  logic [ADDR_W-1:0]  upd_pred_target,
  output logic               mispredict
);
  import tib_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  // slot storage
  logic [ENTRIES-1:0]  valid_q;
  logic [ADDR_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]   target_q [ENTRIES];
  logic [INSTR_W-1:0]  instr_q  [ENTRIES];
  logic [CTR_W-1:0]    ctr_q    [ENTRIES];

  logic [ENTRIES*ADDR_W-1:0] tag_flat;
  logic [ENTRIES*CTR_W-1:0]  ctr_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign tag_flat[i*ADDR_W +: ADDR_W] = tag_q[i];
    assign ctr_flat[i*CTR_W +: CTR_W]   = ctr_q[i];
  end

  // fetch-side lookup
  logic [ENTRIES-1:0] f_match;
  logic               f_any;
  logic [IDX_W-1:0]   f_idx;

  tib_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fetch_cam (
    .key(fetch_addr), .tags_flat(tag_flat), .valid(valid_q),
    .match(f_match), .any(f_any), .idx(f_idx)
  );

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] jump_addr;

  assign seq_addr        = fetch_addr + STEP;
  assign jump_addr       = target_q[f_idx] + STEP;
  assign hit             = fetch_valid && f_any;
  assign pred_taken      = hit && ctr_says_taken(ctr_q[f_idx]);
  assign tgt_instr_valid = pred_taken;
  assign tgt_instr       = instr_q[f_idx];
  assign next_fetch_addr = pred_taken ? jump_addr : seq_addr;

  // update-side lookup
  logic [ENTRIES-1:0] u_match;
  logic               u_any;
  logic [IDX_W-1:0]   u_idx;

  tib_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_upd_cam (
    .key(upd_addr), .tags_flat(tag_flat), .valid(valid_q),
    .match(u_match), .any(u_any), .idx(u_idx)
  );

  // named internal events
  logic             train_ev;
  logic             alloc_fire;
  logic             retarget_ev;
  logic [IDX_W-1:0] rr_ptr;
  logic [ENTRIES-1:0] alloc_vec;

  assign train_ev    = upd_valid && u_any;
  assign alloc_fire  = upd_valid && upd_taken && !u_any;
  assign retarget_ev = train_ev && upd_taken && (target_q[u_idx] != upd_target);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_avec
    assign alloc_vec[i] = alloc_fire && (rr_ptr == IDX_W'(i));
  end

  tib_rr_alloc #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .advance(alloc_fire), .victim(rr_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          valid_q         <= '0;
    else if (alloc_fire) valid_q[rr_ptr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= '0;
    end else if (alloc_fire) begin
      tag_q[rr_ptr]    <= upd_addr;
      target_q[rr_ptr] <= upd_target;
      instr_q[rr_ptr]  <= upd_instr;
      ctr_q[rr_ptr]    <= CTR_INIT;
    end else if (train_ev) begin
      ctr_q[u_idx] <= ctr_train(ctr_q[u_idx], upd_taken);
      if (retarget_ev) begin
        target_q[u_idx] <= upd_target;
        instr_q[u_idx]  <= upd_instr;
      end
    end
  end

  assign mispredict = upd_valid &&
                      wrong_guess(upd_taken, upd_pred_taken,
                                  upd_target != upd_pred_target);
endmodule

// File: rtl/tib_checker.sv
module tib_checker #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic                 hit,
  input logic                 pred_taken,
  input logic                 tgt_instr_valid,
  input logic [ENTRIES-1:0]   f_match,
  input logic [ENTRIES-1:0]   valid_q,
  input logic [2*ENTRIES-1:0] ctr_flat,
  input logic [ENTRIES-1:0]   alloc_vec,
  input logic [IDX_W-1:0]     rr_ptr,
  input logic                 upd_valid,
  input logic                 upd_taken,
  input logic                 upd_pred_taken,
  input logic                 mispredict
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  // R11
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!hit && !pred_taken && !tgt_instr_valid));

  // R3
  taken_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (hit && tgt_instr_valid));

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_match));

  // R9
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_vec) |=> (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1)));

  // R9
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|alloc_vec) |=> $stable(rr_ptr));

  // R5
  alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_vec) |=> ((valid_q & $past(alloc_vec)) == $past(alloc_vec)));

  // R5
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) >= $past($countones(valid_q)));

  // R10
  agree_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_pred_taken) |-> !mispredict);

  // R10
  dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_taken != upd_pred_taken)) |-> mispredict);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ctr
    logic [1:0] c;
    assign c = ctr_flat[2*i +: 2];
    // R7
    ctr_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q[i] && $past(valid_q[i]) && !$past(alloc_vec[i])) |->
      (((c >= $past(c)) ? (c - $past(c)) : ($past(c) - c)) <= 2'd1));
  end
endmodule

bind tgt_instr_buffer tib_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .hit(hit),
  .pred_taken(pred_taken), .tgt_instr_valid(tgt_instr_valid),
  .f_match(f_match), .valid_q(valid_q), .ctr_flat(ctr_flat),
  .alloc_vec(alloc_vec), .rr_ptr(rr_ptr), .upd_valid(upd_valid),
  .upd_taken(upd_taken), .upd_pred_taken(upd_pred_taken),
  .mispredict(mispredict)
);

// File: tb/tgt_instr_buffer_test.sv
`timescale 1ns/1ps
module tgt_instr_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        hit, pred_taken, tgt_instr_valid, mispredict;
  logic [31:0] tgt_instr, next_fetch_addr;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [31:0] upd_instr = '0;
  logic        upd_pred_taken = 1'b0;
  logic [31:0] upd_pred_target = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  tgt_instr_buffer uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .hit(hit), .pred_taken(pred_taken), .tgt_instr_valid(tgt_instr_valid),
    .tgt_instr(tgt_instr), .next_fetch_addr(next_fetch_addr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_instr(upd_instr),
    .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
    .mispredict(mispredict)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    fetch_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic resolve(input logic [31:0] a, input logic t,
                         input logic [31:0] tg, input logic [31:0] ins);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_taken = t;
    upd_target = tg; upd_instr = ins;
    upd_pred_taken = t; upd_pred_target = tg;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr = a;
    #1;
  endtask

  task automatic expect_miss(input string req, input logic [31:0] a);
    look(a);
    check(req, "miss hit", {31'd0, hit}, 32'd0);
    check(req, "miss pred", {31'd0, pred_taken}, 32'd0);
    check(req, "miss instr_valid", {31'd0, tgt_instr_valid}, 32'd0);
    check(req, "miss next", next_fetch_addr, a + 32'd4);
  endtask

  task automatic expect_taken(input string req, input logic [31:0] a,
                              input logic [31:0] tg, input logic [31:0] ins);
    look(a);
    check(req, "taken hit", {31'd0, hit}, 32'd1);
    check(req, "taken pred", {31'd0, pred_taken}, 32'd1);
    check(req, "taken instr_valid", {31'd0, tgt_instr_valid}, 32'd1);
    check(req, "taken instr", tgt_instr, ins);
    check(req, "taken next", next_fetch_addr, tg + 32'd4);
  endtask

  task automatic expect_nt_hit(input string req, input logic [31:0] a);
    look(a);
    check(req, "nt hit", {31'd0, hit}, 32'd1);
    check(req, "nt pred", {31'd0, pred_taken}, 32'd0);
    check(req, "nt next", next_fetch_addr, a + 32'd4);
  endtask

  // R1 R2
  task automatic t_reset_and_miss();
    do_reset();
    expect_miss("R1", 32'h0000_1000);
    expect_miss("R2", 32'h0000_2468);
  endtask

  // R5 R3 R6
  task automatic t_install();
    do_reset();
    resolve(32'h100, 1'b1, 32'h800, 32'hCAFE_0001);
    expect_taken("R5", 32'h100, 32'h800, 32'hCAFE_0001);
    expect_miss("R2", 32'h104);
    resolve(32'h200, 1'b0, 32'h900, 32'hDEAD_0002);
    expect_miss("R6", 32'h200);
  endtask

  // R7 R4
  task automatic t_counter();
    do_reset();
    resolve(32'h300, 1'b1, 32'hA00, 32'h1111_0000);       // 2
    resolve(32'h300, 1'b0, 32'hA00, 32'h1111_0000);       // 1
    expect_nt_hit("R4", 32'h300);
    resolve(32'h300, 1'b0, 32'hA00, 32'h1111_0000);       // 0
    resolve(32'h300, 1'b0, 32'hA00, 32'h1111_0000);       // stays 0
    resolve(32'h300, 1'b1, 32'hA00, 32'h1111_0000);       // 1
    expect_nt_hit("R7 floor", 32'h300);
    resolve(32'h300, 1'b1, 32'hA00, 32'h1111_0000);       // 2
    expect_taken("R7 up", 32'h300, 32'hA00, 32'h1111_0000);
    resolve(32'h300, 1'b1, 32'hA00, 32'h1111_0000);       // 3
    resolve(32'h300, 1'b1, 32'hA00, 32'h1111_0000);       // stays 3
    resolve(32'h300, 1'b0, 32'hA00, 32'h1111_0000);       // 2
    expect_taken("R7 ceiling", 32'h300, 32'hA00, 32'h1111_0000);
    resolve(32'h300, 1'b0, 32'hA00, 32'h1111_0000);       // 1
    expect_nt_hit("R7 down", 32'h300);
  endtask

  // R8
  task automatic t_retarget();
    do_reset();
    resolve(32'h400, 1'b1, 32'hB00, 32'h2222_0001);       // 2
    resolve(32'h400, 1'b1, 32'hC40, 32'h3333_0002);       // 3, new target
    expect_taken("R8 retarget", 32'h400, 32'hC40, 32'h3333_0002);
    resolve(32'h400, 1'b0, 32'hD00, 32'h4444_0003);       // 2, target kept
    expect_taken("R8 nt keeps", 32'h400, 32'hC40, 32'h3333_0002);
  endtask

  // R9
  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 8; i++)
      resolve(32'h1000 + 32'(i) * 32'h10, 1'b1, 32'h8000 + 32'(i) * 32'h40,
              32'h5500_0000 + 32'(i));
    for (int i = 0; i < 8; i++)
      expect_taken("R9 fill", 32'h1000 + 32'(i) * 32'h10,
                   32'h8000 + 32'(i) * 32'h40, 32'h5500_0000 + 32'(i));
    resolve(32'h2000, 1'b1, 32'h9000, 32'h6600_0009);
    expect_miss("R9 evicted", 32'h1000);
    expect_taken("R9 survivor", 32'h1010, 32'h8040, 32'h5500_0001);
    expect_taken("R9 newcomer", 32'h2000, 32'h9000, 32'h6600_0009);
  endtask

  task automatic mp_case(input string req, input logic t, input logic pt,
                         input logic [31:0] tg, input logic [31:0] ptg,
                         input logic exp);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = 32'h7700; upd_taken = t;
    upd_target = tg; upd_instr = 32'h0; upd_pred_taken = pt;
    upd_pred_target = ptg;
    #1 check(req, "mispredict", {31'd0, mispredict}, {31'd0, exp});
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  // R10
  task automatic t_mispredict();
    do_reset();
    mp_case("R10 taken-vs-nt", 1'b0, 1'b1, 32'h40, 32'h40, 1'b1);
    mp_case("R10 nt-vs-taken", 1'b1, 1'b0, 32'h40, 32'h40, 1'b1);
    mp_case("R10 agree nt", 1'b0, 1'b0, 32'h40, 32'h80, 1'b0);
    mp_case("R10 agree taken", 1'b1, 1'b1, 32'h40, 32'h40, 1'b0);
    mp_case("R10 wrong target", 1'b1, 1'b1, 32'h40, 32'h44, 1'b1);
    @(negedge clk);
    #1 check("R10 idle", "mispredict", {31'd0, mispredict}, 32'd0);
  endtask

  // R11
  task automatic t_idle_fetch();
    do_reset();
    resolve(32'h500, 1'b1, 32'hE00, 32'h7777_0001);
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = 32'h500;
    #1;
    check("R11", "idle hit", {31'd0, hit}, 32'd0);
    check("R11", "idle pred", {31'd0, pred_taken}, 32'd0);
    check("R11", "idle instr_valid", {31'd0, tgt_instr_valid}, 32'd0);
    expect_taken("R11 resumes", 32'h500, 32'hE00, 32'h7777_0001);
  endtask

  initial begin
    t_reset_and_miss();
    t_install();
    t_counter();
    t_retarget();
    t_round_robin();
    t_mispredict();
    t_idle_fetch();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule